// File: doc/BRIEF.md
# Temperature-Indexed Dual Setting Controller

This block turns a signed temperature reading into a position in a 72-entry band table, one band per 2 °C from -40 °C up to +102 °C, and drives two independent 8-bit settings from two tables at that position. Readings arrive as 16-bit two's complement values in 8.8 fixed point (°C), each qualified by a one-cycle valid strobe. To stop the band from flipping while the temperature sits near a band edge, the block only moves to a new band once the reading is more than 1 °C past that edge.

Software configures the block through a small register write port. It can turn off automatic setting selection and write the two settings by hand. It can turn off automatic band tracking and set the band position by hand. It can also force both outputs off, as can an external disable pin. The two tables are internal storage behind a separate write port. The band position is reported as a status byte, starting at 0x80 for the coldest band.

Top module: `temp_lut_ctrl`

## Requirements
- R1: While reset is asserted, indexByte reads 0x80, both settings read 0x00 and outOff reads 0.
- R2: indexByte equals 0x80 plus the band position k. Band k covers temperatures from (-40 + 2k) °C up to but not including (-38 + 2k) °C, for k from 0 to 71. After reset the band is 0.
- R3: The band saturates at both ends of the table. Readings below -40 °C give at most 0x80, and readings at or above +102 °C give at most 0xC7. indexByte never leaves the range 0x80 to 0xC7.
- R4: From band k, a reading moves the band up only when it is at least (-37 + 2k) °C, that is 1 °C above the band's upper edge. The new band is then the one that contains (reading - 1 °C).
- R5: From band k, a reading moves the band down only when it is below (-41 + 2k) °C, that is 1 °C below the band's lower edge. The new band is then the one that contains (reading + 1 °C).
- R6: The band changes only on a cycle where tempValid is 1. When tempValid is 0, tempValue has no effect on indexByte. A valid reading changes indexByte on the next clock edge.
- R7: With automatic settings on, setting0 and setting1 show table 0 and table 1 at the current band. They are registered, so they follow a band change one clock after indexByte changes.
- R8: A table write with tblWrEn=1 stores tblData at entry tblAddr of the table chosen by tblSel (0 = table 0, 1 = table 1). A write with tblAddr of 72 or more is ignored. Every entry reads 0xFF after reset.
- R9: Configuration register 0 is the mode byte, reset value 0x03. Bit 0 enables automatic band tracking, bit 1 enables automatic settings, and bit 2 is a software off control. Registers 2 and 3 hold manual values for setting0 and setting1, reset 0x00. With bit 1 clear, the settings show the manual registers two clocks after the write.
- R10: Register 1 is the manual band write. It takes effect only while mode bit 0 is clear, and is ignored otherwise. A written value below 0x80 loads 0x80, and a value above 0xC7 loads 0xC7. While mode bit 0 is clear, valid readings do not move the band.
- R11: When disableIn is 1 or mode bit 2 is set, both settings read 0x00 and outOff reads 1. disableIn acts one clock after it is applied, and the mode bit acts two clocks after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tempValid | input | 1 | One-cycle strobe qualifying tempValue |
| tempValue | input | 16 | Signed temperature, 8.8 fixed point, °C |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgAddr | input | 2 | Register select: 0 mode, 1 manual band, 2 manual setting0, 3 manual setting1 |
| cfgWrData | input | 8 | Configuration write data |
| tblWrEn | input | 1 | Table write strobe |
| tblSel | input | 1 | Table select for writes (0 or 1) |
| tblAddr | input | 7 | Table entry for writes, 0 to 71 |
| tblData | input | 8 | Table write data |
| disableIn | input | 1 | Forces both outputs off while high |
| indexByte | output | 8 | Current band as status byte, 0x80 to 0xC7 |
| setting0 | output | 8 | Registered setting for output 0 |
| setting1 | output | 8 | Registered setting for output 1 |
| outOff | output | 1 | High while both outputs are forced off |

## Verification
The assertions assume a few things about the inputs. Reset is held low for at least one clock edge. The manual band write and a valid reading may arrive in the same cycle, but only one of them can take effect, because the mode bit picks the source. tempValue is always a complete two's complement sample, so every value from -128 °C to almost +128 °C is legal and the saturation logic must cover all of them. The stimulus drives every input on the falling clock edge and holds each strobe for exactly one cycle. It issues at most one register or table write per cycle and keeps readings inside the 8.8 range, including values beyond both table ends.

// File: rtl/temp_lut_pkg.sv
package temp_lut_pkg;

  // table geometry
  localparam int ENTRY_COUNT = 72;
  localparam int IDX_W       = $clog2(ENTRY_COUNT);
  localparam int SET_W       = 8;
  localparam int NUM_OUT     = 2;
  localparam int SEL_W       = $clog2(NUM_OUT);
  localparam int IDX_BYTE_W  = 8;
  localparam logic [IDX_BYTE_W-1:0] IDX_BASE = 8'h80;

  // configuration space
  localparam int CFG_AW        = 2;
  localparam int CFG_DW        = 8;
  localparam int MODE_W        = 3;
  localparam int MODE_AUTO_IDX = 0;
  localparam int MODE_AUTO_SET = 1;
  localparam int MODE_SW_OFF   = 2;
  localparam logic [MODE_W-1:0] MODE_RESET = 3'b011;

  typedef enum logic [CFG_AW-1:0] {
    CFG_MODE  = 2'd0,
    CFG_INDEX = 2'd1,
    CFG_MAN0  = 2'd2,
    CFG_MAN1  = 2'd3
  } cfgAddr_e;

  // strobes and levels handed from control to datapath
  typedef struct packed {
    logic                              trackEn;
    logic                              loadEn;
    logic [IDX_BYTE_W-1:0]             loadByte;
    logic [NUM_OUT-1:0]                tblWr;
    logic [IDX_W-1:0]                  tblAddr;
    logic [SET_W-1:0]                  tblData;
    logic                              autoSet;
    logic                              forceOff;
    logic [NUM_OUT-1:0][SET_W-1:0]     man;
  } ctlStrobes_t;

endpackage

// File: rtl/temp_lut_regs.sv
module temp_lut_regs
  import temp_lut_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tempValid,
  input  logic                  cfgWrEn,
  input  logic [CFG_AW-1:0]     cfgAddr,
  input  logic [CFG_DW-1:0]     cfgWrData,
  input  logic                  tblWrEn,
  input  logic [SEL_W-1:0]      tblSel,
  input  logic [IDX_W-1:0]      tblAddr,
  input  logic [SET_W-1:0]      tblData,
  input  logic                  disableIn,
  output ctlStrobes_t           ctl
);

  logic [MODE_W-1:0]            modeQ;
  logic [NUM_OUT-1:0][SET_W-1:0] manQ;
  logic                         modeWr;
  logic                         autoIdx;
  logic [CFG_DW-MODE_W-1:0]     unusedCfgBits;

  assign modeWr        = cfgWrEn && (cfgAddr == CFG_MODE);
  assign autoIdx       = modeQ[MODE_AUTO_IDX];
  assign unusedCfgBits = cfgWrData[CFG_DW-1:MODE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_RESET;
    end else if (modeWr) begin
      modeQ <= cfgWrData[MODE_W-1:0];
    end
  end

  // one manual setting register per output, placed after CFG_MAN0
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_man
    logic manWr;
    assign manWr = cfgWrEn && (cfgAddr == CFG_AW'(int'(CFG_MAN0) + g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        manQ[g] <= '0;
      end else if (manWr) begin
        manQ[g] <= cfgWrData;
      end
    end
  end

  // table write decode, out-of-range entries dropped
  logic tblInRange;
  assign tblInRange = (int'(tblAddr) < ENTRY_COUNT);

  always_comb begin
    ctl          = '0;
    ctl.trackEn  = tempValid && autoIdx;
    ctl.loadEn   = cfgWrEn && (cfgAddr == CFG_INDEX) && !autoIdx;
    ctl.loadByte = cfgWrData;
    for (int g = 0; g < NUM_OUT; g++) begin
      ctl.tblWr[g] = tblWrEn && tblInRange && (tblSel == SEL_W'(g));
    end
    ctl.tblAddr  = tblAddr;
    ctl.tblData  = tblData;
    ctl.autoSet  = modeQ[MODE_AUTO_SET];
    ctl.forceOff = disableIn || modeQ[MODE_SW_OFF];
    ctl.man      = manQ;
  end

  // R10: a manual band load and temperature tracking never both act
  idx_src_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadEn, ctl.trackEn}));

endmodule

// File: rtl/temp_lut_datapath.sv
module temp_lut_datapath
  import temp_lut_pkg::*;
#(
  parameter int TEMP_W = 16,
  parameter int FRAC_W = 8,
  parameter int LOW_C  = -40,
  parameter int STEP_C = 2,
  parameter int HYST_C = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobes_t                   ctl,
  input  logic signed [TEMP_W-1:0]      tempValue,
  output logic [IDX_BYTE_W-1:0]         indexByte,
  output logic [NUM_OUT-1:0][SET_W-1:0] setOut,
  output logic                          offStatus
);

  localparam int EXT_W = TEMP_W + 3;
  localparam int PAD_W = EXT_W - TEMP_W;
  localparam int ONE_C = 1 << FRAC_W;
  localparam int unsigned BAND_SPAN = STEP_C * ONE_C;
  localparam int unsigned LAST      = ENTRY_COUNT - 1;
  localparam logic signed [EXT_W-1:0] HYST_Q = EXT_W'(HYST_C * ONE_C);
  localparam logic signed [EXT_W-1:0] OFFS_Q = EXT_W'(-LOW_C * ONE_C);
  localparam logic [IDX_BYTE_W-1:0]   IDX_TOP = IDX_BASE + IDX_BYTE_W'(LAST);

  // band that contains an offset-shifted reading, clamped to the table
  function automatic logic [IDX_W-1:0] bandOf(input logic signed [EXT_W-1:0] p);
    int unsigned q;
    if (p < 0) return '0;
    q = 32'(unsigned'(p)) / BAND_SPAN;
    if (q > LAST) return IDX_W'(LAST);
    return IDX_W'(q);
  endfunction

  logic signed [EXT_W-1:0] tExt;
  logic signed [EXT_W-1:0] probeDn;
  logic signed [EXT_W-1:0] probeUp;
  logic [IDX_W-1:0]        bandDn;
  logic [IDX_W-1:0]        bandUp;
  logic [IDX_W-1:0]        idxQ;
  logic [IDX_W-1:0]        trackNext;
  logic [IDX_W-1:0]        loadNext;

  assign tExt    = {{PAD_W{tempValue[TEMP_W-1]}}, tempValue};
  assign probeDn = tExt - HYST_Q + OFFS_Q;
  assign probeUp = tExt + HYST_Q + OFFS_Q;
  assign bandDn  = bandOf(probeDn);
  assign bandUp  = bandOf(probeUp);

  // move only when the reading sits a full hysteresis step outside the band
  always_comb begin
    if (bandDn > idxQ)      trackNext = bandDn;
    else if (bandUp < idxQ) trackNext = bandUp;
    else                    trackNext = idxQ;
  end

  always_comb begin
    if (ctl.loadByte < IDX_BASE)     loadNext = '0;
    else if (ctl.loadByte > IDX_TOP) loadNext = IDX_W'(LAST);
    else                             loadNext = IDX_W'(ctl.loadByte - IDX_BASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (ctl.loadEn) begin
      idxQ <= loadNext;
    end else if (ctl.trackEn) begin
      idxQ <= trackNext;
    end
  end

  assign indexByte = IDX_BASE + IDX_BYTE_W'(idxQ);

  // one table and one output register per output
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic [SET_W-1:0] mem [ENTRY_COUNT];
    logic [SET_W-1:0] setQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < ENTRY_COUNT; e++) mem[e] <= '1;
      end else if (ctl.tblWr[g]) begin
        mem[ctl.tblAddr] <= ctl.tblData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)             setQ <= '0;
      else if (ctl.forceOff) setQ <= '0;
      else if (ctl.autoSet)  setQ <= mem[idxQ];
      else                   setQ <= ctl.man[g];
    end

    assign setOut[g] = setQ;

    // R9
    man_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctl.forceOff && !ctl.autoSet) |=> (setQ == $past(ctl.man[g])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) offStatus <= 1'b0;
    else       offStatus <= ctl.forceOff;
  end

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(idxQ) <= ENTRY_COUNT - 1);

  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.trackEn && !ctl.loadEn) |=> $stable(idxQ));

  // R11
  off_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceOff |=> (offStatus && (setOut == '0)));

endmodule

// File: rtl/temp_lut_ctrl.sv
module temp_lut_ctrl
  import temp_lut_pkg::*;
#(
  parameter int TEMP_W = 16,
  parameter int FRAC_W = 8,
  parameter int LOW_C  = -40,
  parameter int STEP_C = 2,
  parameter int HYST_C = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tempValid,
  input  logic signed [TEMP_W-1:0] tempValue,
  input  logic                     cfgWrEn,
  input  logic [CFG_AW-1:0]        cfgAddr,
  input  logic [CFG_DW-1:0]        cfgWrData,
  input  logic                     tblWrEn,
  input  logic [SEL_W-1:0]         tblSel,
  input  logic [IDX_W-1:0]         tblAddr,
  input  logic [SET_W-1:0]         tblData,
  input  logic                     disableIn,
  output logic [IDX_BYTE_W-1:0]    indexByte,
  output logic [SET_W-1:0]         setting0,
  output logic [SET_W-1:0]         setting1,
  output logic                     outOff
);

  ctlStrobes_t                   ctl;
  logic [NUM_OUT-1:0][SET_W-1:0] setOut;

  temp_lut_regs u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .tempValid (tempValid),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .tblWrEn   (tblWrEn),
    .tblSel    (tblSel),
    .tblAddr   (tblAddr),
    .tblData   (tblData),
    .disableIn (disableIn),
    .ctl       (ctl)
  );

  temp_lut_datapath #(
    .TEMP_W (TEMP_W),
    .FRAC_W (FRAC_W),
    .LOW_C  (LOW_C),
    .STEP_C (STEP_C),
    .HYST_C (HYST_C)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .tempValue (tempValue),
    .indexByte (indexByte),
    .setOut    (setOut),
    .offStatus (outOff)
  );

  assign setting0 = setOut[0];
  assign setting1 = setOut[1];

endmodule

// File: tb/temp_lut_ctrl_tb.sv
module temp_lut_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rstN;
  logic               tempValid;
  logic signed [15:0] tempValue;
  logic               cfgWrEn;
  logic [1:0]         cfgAddr;
  logic [7:0]         cfgWrData;
  logic               tblWrEn;
  logic               tblSel;
  logic [6:0]         tblAddr;
  logic [7:0]         tblData;
  logic               disableIn;
  logic [7:0]         indexByte;
  logic [7:0]         setting0;
  logic [7:0]         setting1;
  logic               outOff;

  always #(CLK_PERIOD / 2) clk = ~clk;

  temp_lut_ctrl u_dut (
    .clk (clk), .rstN (rstN), .tempValid (tempValid), .tempValue (tempValue),
    .cfgWrEn (cfgWrEn), .cfgAddr (cfgAddr), .cfgWrData (cfgWrData),
    .tblWrEn (tblWrEn), .tblSel (tblSel), .tblAddr (tblAddr), .tblData (tblData),
    .disableIn (disableIn), .indexByte (indexByte), .setting0 (setting0),
    .setting1 (setting1), .outOff (outOff)
  );

  typedef struct {
    int       due;
    int       kind;   // 0 index, 1 setting0, 2 setting1, 3 off flag
    string    req;
    bit [7:0] exp;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;

  // bench model
  int       mIdx = 0;
  bit       mAutoIdx = 1, mAutoSet = 1, mSwOff = 0, mDis = 0;
  bit [7:0] mMan0 = 0, mMan1 = 0;
  bit [7:0] tbl0 [72];
  bit [7:0] tbl1 [72];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void check(string req, bit [7:0] act, bit [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h (cycle %0d)", req, act, exp, cyc);
    end
  endfunction

  function automatic bit modelOff();
    return mDis || mSwOff;
  endfunction

  function automatic bit [7:0] modelSet(int g);
    if (modelOff()) return 8'h00;
    if (mAutoSet) return (g == 0) ? tbl0[mIdx] : tbl1[mIdx];
    return (g == 0) ? mMan0 : mMan1;
  endfunction

  function automatic void pushExp(int lat, int kind, string req, bit [7:0] v);
    expItem_t it;
    it.due = cyc + lat; it.kind = kind; it.req = req; it.exp = v;
    expQ.push_back(it);
  endfunction

  function automatic void pushAll(int lat, string req);
    pushExp(lat, 0, req, 8'(8'h80 + mIdx));
    pushExp(lat, 1, req, modelSet(0));
    pushExp(lat, 2, req, modelSet(1));
    pushExp(lat, 3, req, {7'd0, modelOff()});
  endfunction

  // monitor: compare every item that has come due
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due <= cyc) begin
      expItem_t it;
      bit [7:0] act;
      it = expQ.pop_front();
      case (it.kind)
        0: act = indexByte;
        1: act = setting0;
        2: act = setting1;
        default: act = {7'd0, outOff};
      endcase
      check(it.req, act, it.exp);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  // independent band model: walk edge by edge with 1 degree margin
  function automatic void modelTemp(int t);
    if (!mAutoIdx) return;
    while (mIdx < 71 && t >= (-40 + 2 * (mIdx + 1) + 1) * 256) mIdx++;
    while (mIdx > 0 && t < (-40 + 2 * mIdx - 1) * 256) mIdx--;
  endfunction

  task automatic applyTemp(int t, string req);
    tempValue = 16'(t);
    tempValid = 1'b1;
    // R7: settings still show the old band one edge after the strobe
    pushExp(1, 1, "R7", modelSet(0));
    pushExp(1, 2, "R7", modelSet(1));
    modelTemp(t);
    pushExp(1, 0, req, 8'(8'h80 + mIdx));
    pushAll(2, req);
    tick();
    tempValid = 1'b0;
    tick();
  endtask

  task automatic cfgWrite(int a, bit [7:0] d, string req);
    cfgWrEn = 1'b1; cfgAddr = 2'(a); cfgWrData = d;
    case (a)
      0: begin mAutoIdx = d[0]; mAutoSet = d[1]; mSwOff = d[2]; end
      1: if (!mAutoIdx) begin
           if (d < 8'h80) mIdx = 0;
           else if (d > 8'hC7) mIdx = 71;
           else mIdx = int'(d) - 8'h80;
         end
      2: mMan0 = d;
      default: mMan1 = d;
    endcase
    if (a == 1) pushExp(1, 0, req, 8'(8'h80 + mIdx));
    pushAll(2, req);
    tick();
    cfgWrEn = 1'b0;
    tick();
  endtask

  task automatic tblWrite(bit sel, int addr, bit [7:0] d);
    tblWrEn = 1'b1; tblSel = sel; tblAddr = 7'(addr); tblData = d;
    if (addr < 72) begin
      if (sel) tbl1[addr] = d; else tbl0[addr] = d;
    end
    tick();
    tblWrEn = 1'b0;
  endtask

  task automatic setDisable(bit v, string req);
    disableIn = v;
    mDis = v;
    pushAll(1, req);
    pushAll(2, req);
    tick();
    tick();
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 72; i++) begin tbl0[i] = 8'hFF; tbl1[i] = 8'hFF; end
    rstN = 1'b0; tempValid = 1'b0; tempValue = '0; cfgWrEn = 1'b0; cfgAddr = '0;
    cfgWrData = '0; tblWrEn = 1'b0; tblSel = 1'b0; tblAddr = '0; tblData = '0;
    disableIn = 1'b0;
    repeat (3) tick();

    // R1: reset state
    check("R1", indexByte, 8'h80);
    check("R1", setting0, 8'h00);
    check("R1", setting1, 8'h00);
    check("R1", {7'd0, outOff}, 8'h00);

    rstN = 1'b1;
    // R8: tables read 0xFF after reset
    pushAll(2, "R8");
    tick(); tick();

    // R8: fill both tables with distinct patterns
    for (int i = 0; i < 72; i++) tblWrite(1'b0, i, 8'(i * 3 + 1));
    for (int i = 0; i < 72; i++) tblWrite(1'b1, i, 8'(250 - i * 3));
    // R8: out-of-range writes are dropped
    tblWrite(1'b0, 72, 8'h55);
    tblWrite(1'b1, 127, 8'h66);
    pushAll(2, "R8");
    tick(); tick();

    // R3 low clamp, R2 mapping
    applyTemp(-60 * 256, "R3");
    applyTemp(0, "R2");
    applyTemp(25 * 256, "R2");
    // R4: rising hysteresis
    applyTemp(26 * 256 + 128, "R4");
    applyTemp(27 * 256, "R4");
    // R5: falling hysteresis
    applyTemp(25 * 256 + 128, "R5");
    applyTemp(24 * 256 + 192, "R5");
    // R6: reading without strobe is ignored
    tempValue = 16'(50 * 256);
    pushAll(1, "R6");
    pushAll(2, "R6");
    tick(); tick(); tick();
    // R3 high clamp and return
    applyTemp(110 * 256, "R3");
    applyTemp(102 * 256, "R3");
    applyTemp(-41 * 256, "R3");

    // R9: manual settings
    cfgWrite(2, 8'h12, "R9");
    cfgWrite(0, 8'h01, "R9");
    cfgWrite(3, 8'h34, "R9");
    applyTemp(60 * 256, "R9");

    // R10: manual band
    cfgWrite(0, 8'h02, "R10");
    cfgWrite(1, 8'h90, "R10");
    applyTemp(-10 * 256, "R10");
    cfgWrite(1, 8'h20, "R10");
    cfgWrite(1, 8'hF0, "R10");
    cfgWrite(0, 8'h03, "R10");
    cfgWrite(1, 8'h85, "R10");
    applyTemp(0, "R10");

    // R11: off controls
    setDisable(1'b1, "R11");
    setDisable(1'b0, "R11");
    cfgWrite(0, 8'h07, "R11");
    applyTemp(30 * 256, "R11");
    cfgWrite(0, 8'h03, "R11");

    repeat (4) tick();
    finishRun();
  end

endmodule